// File: doc/BRIEF.md
# Branch Condition and Condition-Code Unit

This unit takes one 16-bit instruction word, with the program counter already stepped past that instruction and the four condition flags N, Z, V and C. It decodes three kinds of instruction. Conditional branches evaluate a test on the flags and compute a target address. Condition-code operations set or clear a chosen group of flags. The set-priority-level instruction produces a write strobe carrying a 3-bit level. Any other word is reported as not handled, so a neighbouring decoder can take it.

The result is registered. An instruction presented with `inValid` high at a rising edge appears on the outputs after that edge, with `outValid` high for one cycle. Instruction fetch and any pipelining around the unit are outside its scope.

Top module: `branch_cc_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied, every output reads zero.
- R2: Each instruction sampled with `inValid` high at a rising edge produces exactly one result, with `outValid` high, in the cycle after that edge. `outValid` is low in every cycle that follows an edge where `inValid` was low.
- R3: For high byte 0x01 the branch is always taken. The flag tests for the other high bytes in this group are: 0x02 when Z=0, 0x03 when Z=1, 0x04 when N xor V = 0, 0x05 when N xor V = 1, 0x06 when (N xor V) or Z = 0, and 0x07 when (N xor V) or Z = 1.
- R4: For high bytes 0x80 to 0x87 the branch is taken when, in order: N=0, N=1, C=0 and Z=0, C or Z, V=0, V=1, C=0, C=1.
- R5: A taken branch sets `targetPc` to `pcIn` plus twice the low byte read as a signed 8-bit value, modulo 2^16.
- R6: A branch that is not taken, and every instruction that is not a branch, gives `taken`=0 and `targetPc` equal to `pcIn`.
- R7: A word with bits 15:5 equal to 0b00000000101 and bit 4 = 1 sets each flag whose mask bit is 1. The mask bits are bit 3 for N, bit 2 for Z, bit 1 for V and bit 0 for C. On `flagsIn`/`flagsOut` the order is {N,Z,V,C}, with N at bit 3.
- R8: The same word with bit 4 = 0 clears each flag whose mask bit is 1.
- R9: Flags whose mask bit is 0 keep their input value. Words 0x00A0 and 0x00B0 therefore leave all four flags unchanged.
- R10: Words 0x0098 to 0x009F raise `prioWe`, drive `prioLevel` with bits 2:0 and leave the flags unchanged. For every other word `prioWe` is 0 and `prioLevel` is 0.
- R11: Any word that is not a branch, a condition-code operation or a priority write raises `unhandled` and passes the flags through unchanged. This includes high bytes 0x00, 0x08 and 0x88.
- R12: Branch instructions pass the flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction on the inputs is to be decoded |
| instr | input | 16 | Instruction word |
| pcIn | input | 16 | PC already advanced past the instruction |
| flagsIn | input | 4 | Current flags {N,Z,V,C} |
| outValid | output | 1 | Result registered this cycle |
| taken | output | 1 | Branch is taken |
| targetPc | output | 16 | Next PC |
| flagsOut | output | 4 | Updated flags {N,Z,V,C} |
| prioWe | output | 1 | Priority-level write strobe |
| prioLevel | output | 3 | New priority level |
| unhandled | output | 1 | Word is not decoded by this unit |

## Verification
All fifteen branch codes are run against all sixteen flag combinations. This separates each condition from the polarity of its neighbour, and the signed tests from the unsigned ones. Branch offsets are taken at +127, -128, 0 and -1, with program counters near 0x0000 and 0xFFFF, so that sign extension, the doubling of the offset and wrap-around each show up as a distinct wrong target. All 32 condition-code words are applied to several flag values, including all-ones and all-zeros. A set is thereby told apart from a clear, and a selected flag from an unselected one. A sweep of the words around each decoded range, 0x0080 to 0x00BF together with high bytes 0x00, 0x08, 0x7F, 0x88 and 0xFF, shows where the priority-write, condition-code and not-handled regions begin and end.

// File: rtl/brcc_pkg.sv
package brcc_pkg;
  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  typedef struct packed {
    logic       isBranch;
    logic       condGroup;   // 0: high byte 0x0X, 1: high byte 0x8X
    logic [2:0] condCode;
    logic       isCcop;
    logic       ccSet;
    logic [3:0] ccMask;
    logic       isSpl;
    logic       unknown;
  } ctrlStrobes_t;
endpackage

// File: rtl/brcc_decode.sv
module brcc_decode
  import brcc_pkg::*;
(
  input  logic [15:0]  instr,
  output ctrlStrobes_t strobes
);
  logic [7:0] hiByte;
  logic       brLow, brHigh, ccHit, splHit;

  assign hiByte = instr[15:8];
  assign brLow  = (hiByte[7:3] == 5'b00000) && (hiByte[2:0] != 3'd0);
  assign brHigh = (hiByte[7:3] == 5'b10000);
  assign ccHit  = (instr[15:5] == 11'b00000000101);
  assign splHit = (instr[15:3] == 13'b0000000010011);

  always_comb begin
    strobes           = '0;
    strobes.isBranch  = brLow | brHigh;
    strobes.condGroup = hiByte[7];
    strobes.condCode  = hiByte[2:0];
    strobes.isCcop    = ccHit;
    strobes.ccSet     = instr[4];
    strobes.ccMask    = instr[3:0];
    strobes.isSpl     = splHit;
    strobes.unknown   = !(brLow | brHigh | ccHit | splHit);
  end
endmodule

// File: rtl/brcc_datapath.sv
module brcc_datapath
  import brcc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  ctrlStrobes_t      strobes,
  input  logic [7:0]        offset,
  input  logic [2:0]        levelIn,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              takenNext,
  output logic [PC_W-1:0]   targetNext,
  output logic [FLAG_W-1:0] flagsNext,
  output logic              prioWeNext,
  output logic [2:0]        prioLevelNext,
  output logic              unhandledNext
);
  localparam int EXT_W = PC_W - 9;

  logic n, z, v, c, nxv, condMet;
  logic [PC_W-1:0] stepBytes;

  assign n   = flagsIn[FLAG_N];
  assign z   = flagsIn[FLAG_Z];
  assign v   = flagsIn[FLAG_V];
  assign c   = flagsIn[FLAG_C];
  assign nxv = n ^ v;

  always_comb begin
    condMet = 1'b0;
    if (!strobes.condGroup) begin
      unique case (strobes.condCode)
        3'd1:    condMet = 1'b1;
        3'd2:    condMet = !z;
        3'd3:    condMet = z;
        3'd4:    condMet = !nxv;
        3'd5:    condMet = nxv;
        3'd6:    condMet = !(nxv | z);
        3'd7:    condMet = nxv | z;
        default: condMet = 1'b0;
      endcase
    end else begin
      unique case (strobes.condCode)
        3'd0: condMet = !n;
        3'd1: condMet = n;
        3'd2: condMet = !c && !z;
        3'd3: condMet = c | z;
        3'd4: condMet = !v;
        3'd5: condMet = v;
        3'd6: condMet = !c;
        3'd7: condMet = c;
      endcase
    end
  end

  assign stepBytes  = {{EXT_W{offset[7]}}, offset, 1'b0};
  assign takenNext  = strobes.isBranch && condMet;
  assign targetNext = takenNext ? (pcIn + stepBytes) : pcIn;

  always_comb begin
    flagsNext = flagsIn;
    if (strobes.isCcop) begin
      if (strobes.ccSet) flagsNext = flagsIn | strobes.ccMask;
      else               flagsNext = flagsIn & ~strobes.ccMask;
    end
  end

  assign prioWeNext    = strobes.isSpl;
  assign prioLevelNext = strobes.isSpl ? levelIn : 3'd0;
  assign unhandledNext = strobes.unknown;
endmodule

// File: rtl/branch_cc_unit.sv
module branch_cc_unit
  import brcc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [15:0]       instr,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   targetPc,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              prioWe,
  output logic [2:0]        prioLevel,
  output logic              unhandled
);
  ctrlStrobes_t      strobes;
  logic              takenNext, prioWeNext, unhandledNext;
  logic [PC_W-1:0]   targetNext;
  logic [FLAG_W-1:0] flagsNext;
  logic [2:0]        prioLevelNext;

  brcc_decode decode_i (
    .instr   (instr),
    .strobes (strobes)
  );

  brcc_datapath #(.PC_W(PC_W)) datapath_i (
    .strobes       (strobes),
    .offset        (instr[7:0]),
    .levelIn       (instr[2:0]),
    .pcIn          (pcIn),
    .flagsIn       (flagsIn),
    .takenNext     (takenNext),
    .targetNext    (targetNext),
    .flagsNext     (flagsNext),
    .prioWeNext    (prioWeNext),
    .prioLevelNext (prioLevelNext),
    .unhandledNext (unhandledNext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      taken     <= 1'b0;
      targetPc  <= '0;
      flagsOut  <= '0;
      prioWe    <= 1'b0;
      prioLevel <= 3'd0;
      unhandled <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        taken     <= takenNext;
        targetPc  <= targetNext;
        flagsOut  <= flagsNext;
        prioWe    <= prioWeNext;
        prioLevel <= prioLevelNext;
        unhandled <= unhandledNext;
      end else begin
        taken     <= 1'b0;
        prioWe    <= 1'b0;
        prioLevel <= 3'd0;
        unhandled <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brcc_checker.sv
module brcc_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            inValid,
  input logic [15:0]     instr,
  input logic [PC_W-1:0] pcIn,
  input logic [3:0]      flagsIn,
  input logic            outValid,
  input logic            taken,
  input logic [PC_W-1:0] targetPc,
  input logic [3:0]      flagsOut,
  input logic            prioWe,
  input logic [2:0]      prioLevel,
  input logic            unhandled
);
  assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (outValid == $past(inValid)));

  assert_exclusive_kinds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, prioWe, unhandled}));

  assert_pc_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !taken) |-> (targetPc == $past(pcIn)));

  assert_even_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && taken) |-> (targetPc[0] == $past(pcIn[0])));

  assert_flags_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && taken) |-> (flagsOut == $past(flagsIn)));

  assert_spl_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prioWe |-> (outValid && flagsOut == $past(flagsIn) && prioLevel == $past(instr[2:0])));

  assert_unknown_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> (outValid && flagsOut == $past(flagsIn)));
endmodule

bind branch_cc_unit brcc_checker #(.PC_W(PC_W)) checker_i (.*);

// File: tb/branch_cc_unit_tb_top.sv
`timescale 1ns/1ps
module branch_cc_unit_tb_top;
  typedef struct {
    logic        taken;
    logic [15:0] target;
    logic [3:0]  flags;
    logic        prioWe;
    logic [2:0]  prioLevel;
    logic        unhandled;
    string       req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pcIn = '0;
  logic [3:0]  flagsIn = '0;
  logic outValid, taken, prioWe, unhandled;
  logic [15:0] targetPc;
  logic [3:0]  flagsOut;
  logic [2:0]  prioLevel;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  expItem_t sb[$];

  always #2.5 clk = ~clk;

  branch_cc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr), .pcIn(pcIn),
    .flagsIn(flagsIn), .outValid(outValid), .taken(taken), .targetPc(targetPc),
    .flagsOut(flagsOut), .prioWe(prioWe), .prioLevel(prioLevel), .unhandled(unhandled)
  );

  function automatic logic condOf(input logic [7:0] hi, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (hi)
      8'h01: return 1'b1;
      8'h02: return !z;
      8'h03: return z;
      8'h04: return (n == v);
      8'h05: return (n != v);
      8'h06: return (n == v) && !z;
      8'h07: return (n != v) || z;
      8'h80: return !n;
      8'h81: return n;
      8'h82: return !c && !z;
      8'h83: return c || z;
      8'h84: return !v;
      8'h85: return v;
      8'h86: return !c;
      8'h87: return c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [15:0] w, input logic [15:0] pc,
                      input logic [3:0] f, input string req);
    expItem_t e;
    logic [7:0] hi;
    logic isBr, isCc, isSpl;
    hi = w[15:8];
    isBr  = (hi >= 8'h01 && hi <= 8'h07) || (hi >= 8'h80 && hi <= 8'h87);
    isCc  = (w >= 16'h00A0 && w <= 16'h00BF);
    isSpl = (w >= 16'h0098 && w <= 16'h009F);
    e.req = req;
    e.taken = isBr && condOf(hi, f);
    e.target = e.taken ? 16'(pc + 16'(2 * int'($signed(w[7:0])))) : pc;
    e.flags = f;
    if (isCc) e.flags = w[4] ? (f | w[3:0]) : (f & ~w[3:0]);
    e.prioWe = isSpl;
    e.prioLevel = isSpl ? w[2:0] : 3'd0;
    e.unhandled = !(isBr || isCc || isSpl);
    @(negedge clk); #1;
    inValid = 1'b1; instr = w; pcIn = pc; flagsIn = f;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      inValid = 1'b0;
    end
  endtask

  // monitor: compares each registered result against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        if (outValid) begin
          if (sb.size() == 0) begin
            errors++; checks++;
            $display("FAIL R2 unexpected outValid: actual 1 expected 0");
          end else begin
            expItem_t e;
            e = sb.pop_front();
            checks++;
            if (taken !== e.taken || targetPc !== e.target || flagsOut !== e.flags ||
                prioWe !== e.prioWe || prioLevel !== e.prioLevel || unhandled !== e.unhandled) begin
              errors++;
              $display("FAIL %s instr=%h: actual t=%b pc=%h f=%b we=%b lv=%0d u=%b expected t=%b pc=%h f=%b we=%b lv=%0d u=%b",
                       e.req, instr, taken, targetPc, flagsOut, prioWe, prioLevel, unhandled,
                       e.taken, e.target, e.flags, e.prioWe, e.prioLevel, e.unhandled);
            end
          end
        end else if (sb.size() != 0) begin
          errors++; checks++;
          $display("FAIL R2 missing result: actual outValid 0 expected 1");
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] odd[10];
    odd = '{16'h0000, 16'h0001, 16'h00FF, 16'h0800, 16'h08FF,
            16'h8800, 16'h88FF, 16'h7F12, 16'hFF00, 16'h00C0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if ({outValid, taken, targetPc, flagsOut, prioWe, prioLevel, unhandled} !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b expected 0",
               {outValid, taken, targetPc, flagsOut, prioWe, prioLevel, unhandled});
    end
    rst_n = 1'b1;
    idle(2);

    // R3 / R4 / R12: every branch code against every flag combination
    for (int h = 1; h <= 7; h++)
      for (int f = 0; f < 16; f++)
        send({8'(h), 8'h10}, 16'h1000, 4'(f), "R3");
    for (int h = 8'h80; h <= 8'h87; h++)
      for (int f = 0; f < 16; f++)
        send({8'(h), 8'hF0}, 16'h2000, 4'(f), "R4");
    idle(1);

    // R5 offsets and wrap
    send(16'h017F, 16'h1000, 4'h0, "R5");
    send(16'h0180, 16'h1000, 4'h0, "R5");
    send(16'h0100, 16'h1234, 4'h0, "R5");
    send(16'h01FF, 16'h0000, 4'h0, "R5");
    send(16'h0110, 16'hFFF0, 4'h0, "R5");
    send(16'h0180, 16'h0040, 4'h0, "R5");
    // R6 not taken keeps PC
    send(16'h0380, 16'hABCE, 4'h0, "R6");
    send(16'h8710, 16'h0002, 4'h0, "R6");
    idle(2);

    // R7 / R8 / R9 condition-code operations
    for (int m = 0; m < 16; m++) begin
      send(16'h00B0 | 16'(m), 16'h0100, 4'b0000, "R7");
      send(16'h00B0 | 16'(m), 16'h0100, 4'b0101, "R7");
      send(16'h00A0 | 16'(m), 16'h0100, 4'b1111, "R8");
      send(16'h00A0 | 16'(m), 16'h0100, 4'b1010, "R8");
    end
    send(16'h00A0, 16'h0200, 4'b1001, "R9");
    send(16'h00B0, 16'h0200, 4'b0110, "R9");

    // R10 priority level
    for (int l = 0; l < 8; l++) send(16'h0098 | 16'(l), 16'h0300, 4'(l * 2), "R10");

    // R11 boundaries and other words
    for (int w = 16'h0080; w < 16'h0098; w++) send(16'(w), 16'h0400, 4'b1100, "R11");
    foreach (odd[i]) send(odd[i], 16'h0400, 4'b0011, "R11");
    idle(1);
    send(16'h0200, 16'h0500, 4'b0000, "R2");
    idle(3);

    // R2 every result delivered
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 pending results: actual %0d expected 0", sb.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule